// File: doc/BRIEF.md
# Cash-Withdrawal Session Sequencer

This block steps one cash-withdrawal session through eight states. It starts at power-up idle and waits at the welcome screen between sessions. A session moves through PIN checking, amount entry, a balance check and a bill-availability check. It then pays out, or stops early, and always ends by ejecting the card. The surrounding system reports outcomes as single-cycle event strobes. These cover start, card inserted, PIN good, PIN bad, amount within limit, amount over limit, cancel, funds sufficient, funds short, bills sufficient and bills short. The block answers with a 3-bit state code and one-cycle command pulses to the checking units and to the two motors.

The PIN comparison, the account lookup, the bill counting, the display and the keypad decoding are done elsewhere. They return their verdicts as event strobes. The amount checker accepts requests from 5 to 1000 units. Anything outside that window comes back as the over-limit event. A session counter gives a running count of completed sessions.

The states are named as follows. Idle is code 0 and welcome is 1. PIN check is 2 and amount entry is 3. Balance check is 4 and bill check is 5. Disburse is 6 and eject is 7.

The transitions are:
- idle to welcome on start
- welcome to PIN check on card inserted
- PIN check to amount entry on PIN good
- PIN check to itself on PIN bad
- PIN check to eject on cancel
- amount entry to balance check on amount within limit
- amount entry to itself on amount over limit
- amount entry to eject on cancel
- balance check to bill check on funds sufficient
- balance check to eject on funds short
- bill check to disburse on bills sufficient
- bill check to eject on bills short
- disburse to eject, unconditionally
- eject to welcome, unconditionally

Top module: `atm_session_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state code at 0, drives every command output low and clears the session count.
- R2: State codes are 0 idle, 1 welcome, 2 PIN check, 3 amount entry, 4 balance check, 5 bill check, 6 disburse and 7 eject. Idle goes to welcome on start, and welcome goes to PIN check on card inserted.
- R3: In PIN check, PIN good goes to amount entry, PIN bad stays in PIN check and cancel goes to eject.
- R4: In amount entry, an amount within limit goes to balance check, an amount over limit stays in amount entry and cancel goes to eject.
- R5: In balance check, funds sufficient goes to bill check and funds short goes to eject. In bill check, bills sufficient goes to disburse and bills short goes to eject.
- R6: Disburse always moves to eject, and eject always moves to welcome, on the next clock, whatever the event inputs do.
- R7: An event not listed for the current state is ignored, and the state code holds. With no event, every state except disburse and eject holds.
- R8: Events are numbered 0 start, 1 card, 2 PIN good, 3 PIN bad, 4 amount within, 5 amount over, 6 cancel, 7 funds sufficient, 8 funds short, 9 bills sufficient and 10 bills short. When several are active together, cancel wins in PIN check and amount entry. Otherwise the lowest-numbered event listed for the state wins.
- R9: The disburse output is high exactly in the cycle spent in disburse. The eject output is high exactly in the cycle spent in eject.
- R10: The PIN, balance and bill check requests each pulse high for one cycle. The pulse comes in the first cycle after a transition into PIN check, balance check or bill check respectively. The PIN bad self-loop counts as a transition into PIN check. Holding in a state does not.
- R11: The session count rises by one on each move from eject to welcome and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start strobe (event 0) |
| ev_card | input | 1 | Card inserted strobe (event 1) |
| ev_pin_ok | input | 1 | PIN good strobe (event 2) |
| ev_pin_bad | input | 1 | PIN bad strobe (event 3) |
| ev_amt_ok | input | 1 | Amount within limit strobe (event 4) |
| ev_amt_over | input | 1 | Amount over limit strobe (event 5) |
| ev_cancel | input | 1 | Cancel strobe (event 6) |
| ev_funds_ok | input | 1 | Funds sufficient strobe (event 7) |
| ev_funds_low | input | 1 | Funds short strobe (event 8) |
| ev_bills_ok | input | 1 | Bills sufficient strobe (event 9) |
| ev_bills_low | input | 1 | Bills short strobe (event 10) |
| state_code | output | 3 | Current state code |
| pin_check_req | output | 1 | PIN check request pulse |
| balance_check_req | output | 1 | Balance check request pulse |
| bills_check_req | output | 1 | Bill availability check request pulse |
| disburse_on | output | 1 | Disburse motor drive |
| eject_on | output | 1 | Card eject motor drive |
| session_count | output | CNT_W | Completed session count |

## Verification
The disburse state is the hardest point to reach and to test. It lasts one cycle and can only be entered after a full chain of four correct verdicts. The bench therefore replays that whole path from reset before each trial. It then applies every single event, and every pair of events, in the one cycle the machine sits there. Each state is handled the same way, and every outcome is compared with a next-state model written from the transition list. The counter wrap is reached by building the bench with a 4-bit count and running seventeen short cancel sessions.

// File: rtl/atm_sess_pkg.sv
package atm_sess_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WELCOME  = 3'd1,
        ST_PIN      = 3'd2,
        ST_AMOUNT   = 3'd3,
        ST_BALANCE  = 3'd4,
        ST_BILLS    = 3'd5,
        ST_DISBURSE = 3'd6,
        ST_EJECT    = 3'd7
    } sess_state_t;

    localparam int NUM_EVT      = 11;
    localparam int EV_START     = 0;
    localparam int EV_CARD      = 1;
    localparam int EV_PIN_OK    = 2;
    localparam int EV_PIN_BAD   = 3;
    localparam int EV_AMT_OK    = 4;
    localparam int EV_AMT_OVER  = 5;
    localparam int EV_CANCEL    = 6;
    localparam int EV_FUNDS_OK  = 7;
    localparam int EV_FUNDS_LOW = 8;
    localparam int EV_BILLS_OK  = 9;
    localparam int EV_BILLS_LOW = 10;

endpackage

// File: rtl/atm_event_select.sv
module atm_event_select
    import atm_sess_pkg::*;
(
    input  sess_state_t          cur,
    input  logic [NUM_EVT-1:0]   evt,
    output sess_state_t          nxt,
    output logic                 moved
);

    // Priority per state: cancel first where it applies, then lowest index.
    always_comb begin
        nxt   = cur;
        moved = 1'b0;
        unique case (cur)
            ST_IDLE: begin
                if (evt[EV_START]) begin
                    nxt = ST_WELCOME; moved = 1'b1;
                end
            end
            ST_WELCOME: begin
                if (evt[EV_CARD]) begin
                    nxt = ST_PIN; moved = 1'b1;
                end
            end
            ST_PIN: begin
                if (evt[EV_CANCEL]) begin
                    nxt = ST_EJECT; moved = 1'b1;
                end else if (evt[EV_PIN_OK]) begin
                    nxt = ST_AMOUNT; moved = 1'b1;
                end else if (evt[EV_PIN_BAD]) begin
                    nxt = ST_PIN; moved = 1'b1;
                end
            end
            ST_AMOUNT: begin
                if (evt[EV_CANCEL]) begin
                    nxt = ST_EJECT; moved = 1'b1;
                end else if (evt[EV_AMT_OK]) begin
                    nxt = ST_BALANCE; moved = 1'b1;
                end else if (evt[EV_AMT_OVER]) begin
                    nxt = ST_AMOUNT; moved = 1'b1;
                end
            end
            ST_BALANCE: begin
                if (evt[EV_FUNDS_OK]) begin
                    nxt = ST_BILLS; moved = 1'b1;
                end else if (evt[EV_FUNDS_LOW]) begin
                    nxt = ST_EJECT; moved = 1'b1;
                end
            end
            ST_BILLS: begin
                if (evt[EV_BILLS_OK]) begin
                    nxt = ST_DISBURSE; moved = 1'b1;
                end else if (evt[EV_BILLS_LOW]) begin
                    nxt = ST_EJECT; moved = 1'b1;
                end
            end
            ST_DISBURSE: begin
                nxt = ST_EJECT; moved = 1'b1;
            end
            ST_EJECT: begin
                nxt = ST_WELCOME; moved = 1'b1;
            end
            default: begin
                nxt = ST_IDLE; moved = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/atm_cmd_pulse.sv
module atm_cmd_pulse
    import atm_sess_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sess_state_t cur,
    input  sess_state_t nxt,
    input  logic        moved,
    output logic        pin_req,
    output logic        bal_req,
    output logic        bill_req,
    output logic        disburse_on,
    output logic        eject_on
);

    // Check requests are registered so they line up with the first cycle in the target state.
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_req  <= 1'b0;
            bal_req  <= 1'b0;
            bill_req <= 1'b0;
        end else begin
            pin_req  <= moved && (nxt == ST_PIN);
            bal_req  <= moved && (nxt == ST_BALANCE);
            bill_req <= moved && (nxt == ST_BILLS);
        end
    end

    always_comb begin
        disburse_on = (cur == ST_DISBURSE);
        eject_on    = (cur == ST_EJECT);
    end

    AST_PIN_REQ_IN_PIN: assert property (@(posedge clk) disable iff (rst)
        pin_req |-> (cur == ST_PIN)) else $error("pin request outside PIN check"); // R10
    AST_BAL_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bal_req |=> !bal_req) else $error("balance request longer than one cycle"); // R10
    AST_DISB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        disburse_on |=> !disburse_on) else $error("disburse longer than one cycle"); // R9
    AST_EJECT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eject_on |=> !eject_on) else $error("eject longer than one cycle"); // R9

endmodule

// File: rtl/atm_session_counter.sv
module atm_session_counter
    import atm_sess_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sess_state_t      cur,
    input  sess_state_t      nxt,
    output logic [CNT_W-1:0] count
);

    logic done;
    assign done = (cur == ST_EJECT) && (nxt == ST_WELCOME);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (done) count <= count + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_EJECT) |=> (count == CNT_W'($past(count) + 1'b1)))
        else $error("session count did not advance"); // R11
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur != ST_EJECT) |=> $stable(count))
        else $error("session count moved mid-session"); // R11

endmodule

// File: rtl/atm_session_ctrl.sv
module atm_session_ctrl
    import atm_sess_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_start,
    input  logic             ev_card,
    input  logic             ev_pin_ok,
    input  logic             ev_pin_bad,
    input  logic             ev_amt_ok,
    input  logic             ev_amt_over,
    input  logic             ev_cancel,
    input  logic             ev_funds_ok,
    input  logic             ev_funds_low,
    input  logic             ev_bills_ok,
    input  logic             ev_bills_low,
    output logic [2:0]       state_code,
    output logic             pin_check_req,
    output logic             balance_check_req,
    output logic             bills_check_req,
    output logic             disburse_on,
    output logic             eject_on,
    output logic [CNT_W-1:0] session_count
);

    logic [NUM_EVT-1:0] evt;
    sess_state_t        cur_q;
    sess_state_t        nxt;
    logic               moved;

    assign evt = {ev_bills_low, ev_bills_ok, ev_funds_low, ev_funds_ok, ev_cancel,
                  ev_amt_over, ev_amt_ok, ev_pin_bad, ev_pin_ok, ev_card, ev_start};

    atm_event_select u_sel (
        .cur   (cur_q),
        .evt   (evt),
        .nxt   (nxt),
        .moved (moved)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_IDLE;
        else     cur_q <= nxt;
    end

    atm_cmd_pulse u_cmd (
        .clk         (clk),
        .rst         (rst),
        .cur         (cur_q),
        .nxt         (nxt),
        .moved       (moved),
        .pin_req     (pin_check_req),
        .bal_req     (balance_check_req),
        .bill_req    (bills_check_req),
        .disburse_on (disburse_on),
        .eject_on    (eject_on)
    );

    atm_session_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur_q),
        .nxt   (nxt),
        .count (session_count)
    );

    assign state_code = cur_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (state_code == 3'd0)) else $error("reset did not reach idle"); // R1
    AST_DISB_TO_EJECT: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd6) |=> (state_code == 3'd7)) else $error("disburse did not eject"); // R6
    AST_EJECT_TO_WELCOME: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd7) |=> (state_code == 3'd1)) else $error("eject did not return"); // R6
    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 3'd2 || state_code == 3'd3) && ev_cancel) |=> (state_code == 3'd7))
        else $error("cancel lost priority"); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 3'd0) && !ev_start) |=> (state_code == 3'd0))
        else $error("idle left without start"); // R7

endmodule

// File: tb/atm_session_ctrl_test.sv
module atm_session_ctrl_test;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [10:0]   ev  = '0;
    logic [2:0]    state_code;
    logic          pin_req, bal_req, bill_req, disb, ejct;
    logic [CW-1:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    atm_session_ctrl #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst),
        .ev_start(ev[0]), .ev_card(ev[1]), .ev_pin_ok(ev[2]), .ev_pin_bad(ev[3]),
        .ev_amt_ok(ev[4]), .ev_amt_over(ev[5]), .ev_cancel(ev[6]),
        .ev_funds_ok(ev[7]), .ev_funds_low(ev[8]), .ev_bills_ok(ev[9]), .ev_bills_low(ev[10]),
        .state_code(state_code), .pin_check_req(pin_req), .balance_check_req(bal_req),
        .bills_check_req(bill_req), .disburse_on(disb), .eject_on(ejct), .session_count(cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [10:0] v);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Expected next state, written from the transition list and priority rule.
    function automatic void model(input int s, input logic [10:0] v,
                                  output int ns, output bit hit, output bit pin_loop);
        ns = s; hit = 1'b0; pin_loop = 1'b0;
        case (s)
            0: if (v[0]) begin ns = 1; hit = 1; end
            1: if (v[1]) begin ns = 2; hit = 1; end
            2: if (v[6]) begin ns = 7; hit = 1; end
               else if (v[2]) begin ns = 3; hit = 1; end
               else if (v[3]) begin ns = 2; hit = 1; pin_loop = 1; end
            3: if (v[6]) begin ns = 7; hit = 1; end
               else if (v[4]) begin ns = 4; hit = 1; end
               else if (v[5]) begin ns = 3; hit = 1; end
            4: if (v[7]) begin ns = 5; hit = 1; end
               else if (v[8]) begin ns = 7; hit = 1; end
            5: if (v[9]) begin ns = 6; hit = 1; end
               else if (v[10]) begin ns = 7; hit = 1; end
            6: begin ns = 7; hit = 1; end
            default: begin ns = 1; hit = 1; end
        endcase
    endfunction

    function automatic string stag(input int s);
        case (s)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            4, 5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // Walk from reset to state s along the success path (eject via cancel).
    task automatic goto_state(input int s);
        do_reset();
        if (s >= 1) step(11'd1 << 0);
        if (s == 7) begin
            step(11'd1 << 1);
            step(11'd1 << 6);
        end else begin
            if (s >= 2) step(11'd1 << 1);
            if (s >= 3) step(11'd1 << 2);
            if (s >= 4) step(11'd1 << 4);
            if (s >= 5) step(11'd1 << 7);
            if (s >= 6) step(11'd1 << 9);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ns;
        bit hit, lp;
        int c0;
        logic [10:0] v;

        // R1: reset state
        do_reset();
        check("R1 state", state_code, 0);
        check("R1 pin_req", pin_req, 0);
        check("R1 bal_req", bal_req, 0);
        check("R1 bill_req", bill_req, 0);
        check("R1 disburse", disb, 0);
        check("R1 eject", ejct, 0);
        check("R1 count", cnt, 0);

        // Single-event sweep over every state (e = -1 means no event)
        for (int s = 0; s < 8; s++) begin
            for (int e = -1; e < 11; e++) begin
                v = (e < 0) ? 11'd0 : (11'd1 << e);
                goto_state(s);
                check("R2 path", state_code, s);
                c0 = cnt;
                model(s, v, ns, hit, lp);
                step(v);
                check(hit ? stag(s) : "R7", state_code, ns);
                check("R9 disburse", disb, (ns == 6) ? 1 : 0);
                check("R9 eject", ejct, (ns == 7) ? 1 : 0);
                check("R10 pin_req", pin_req, (ns == 2 && (s != 2 || lp)) ? 1 : 0);
                check("R10 bal_req", bal_req, (ns == 4 && s != 4) ? 1 : 0);
                check("R10 bill_req", bill_req, (ns == 5 && s != 5) ? 1 : 0);
                check("R11 count", cnt, (s == 7) ? ((c0 + 1) % (1 << CW)) : c0);
            end
        end

        // R8: every pair of simultaneous events in every state
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 11; a++) begin
                for (int b = a + 1; b < 11; b++) begin
                    v = (11'd1 << a) | (11'd1 << b);
                    goto_state(s);
                    model(s, v, ns, hit, lp);
                    step(v);
                    check("R8 pair", state_code, ns);
                end
            end
        end

        // R4: amount responder over a window of requested amounts
        for (int k = 0; k < 6; k++) begin
            int amt;
            bit ok;
            case (k)
                0: amt = 4;
                1: amt = 5;
                2: amt = 1000;
                3: amt = 1001;
                4: amt = 0;
                default: amt = 250;
            endcase
            ok = (amt >= 5) && (amt <= 1000);
            goto_state(3);
            step(ok ? (11'd1 << 4) : (11'd1 << 5));
            check("R4 amount", state_code, ok ? 4 : 3);
        end

        // R10: repeated wrong PIN re-requests the check each time, hold does not
        goto_state(2);
        step(11'd1 << 3);
        check("R10 loop1", pin_req, 1);
        step(11'd0);
        check("R10 hold", pin_req, 0);
        step(11'd1 << 3);
        check("R10 loop2", pin_req, 1);

        // R11: counter wrap with a small width
        do_reset();
        step(11'd1 << 0);
        for (int n = 1; n <= 17; n++) begin
            step(11'd1 << 1);
            step(11'd1 << 6);
            step(11'd0);
            check("R11 wrap", cnt, n % (1 << CW));
        end
        check("R6 back to welcome", state_code, 1);

        // R1: reset mid-session
        goto_state(4);
        do_reset();
        check("R1 mid reset", state_code, 0);
        check("R1 mid count", cnt, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule